// File: doc/BRIEF.md
# Serial Port Interrupt Status Unit

This block produces the interrupt request for a synchronous serial port. It watches four conditions. The first is a receive overrun, where a frame lands while the receive FIFO is already full. The second is a receive time-out, where received data sits unread and the line stays quiet. The other two are level conditions: the receive FIFO is at least half full, or the transmit FIFO is at least half empty. The serial shifter and the FIFO storage sit elsewhere. This block sees them only through the two occupancy levels, a frame-arrival strobe, a FIFO-read strobe and a one-cycle tick for each serial bit time. On an overrun the FIFO side lets the newest frame replace the one before it, and this block only records that this happened.

Software uses a small register port. Address 0 holds a four-bit enable register. Address 1 shows the raw status of every source, whether or not it is enabled. Address 2 shows the raw status ANDed with the enables. Address 3 is a write-only clear register. The single interrupt line is the OR of the enabled status bits. Reads have one cycle of latency, and the interrupt line is registered.

Top module: `spi_irq_unit`

## Requirements
- R1: After reset the enable register is 0 and `irq` is 0. With both levels at 0, raw status reads 0x08.
- R2: A write to address 0 loads `reg_wdata[3:0]` into the enables. Bit 0 is overrun, bit 1 time-out, bit 2 receive half-full, bit 3 transmit half-empty, and a 1 enables the source. Reading address 0 returns the enables.
- R3: Time-out status (bit 1) sets at the edge of the 32nd `bit_tick` counted while `rx_level` is nonzero and no `frame_rcvd` or `fifo_rd` occurs. A frame, a read, or an empty receive FIFO restarts the count from zero.
- R4: Overrun status (bit 0) sets when `frame_rcvd` is high while `rx_level` equals the FIFO depth. It stays set until a write to address 3 with data bit 0 high. A new overrun in the same cycle wins over the clear.
- R5: Time-out status clears when `frame_rcvd` is high. A write to address 3 with data bit 1 clears it only while `rx_level` is 0.
- R6: Raw bit 2 is 1 exactly when `rx_level` >= depth/2. Raw bit 3 is 1 exactly when `tx_level` <= depth/2.
- R7: Address 1 returns raw status regardless of the enables. Address 2 returns raw status ANDed with the enables.
- R8: `irq` equals the OR of the enabled status bits as they stood before the previous clock edge.
- R9: Bits 7:4 of every read are 0. Reads of address 3 return 0. Writes to addresses 1 and 2, and to enable bits 7:4, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_level | input | LVL_W | Receive FIFO occupancy (0..DEPTH) |
| tx_level | input | LVL_W | Transmit FIFO occupancy (0..DEPTH) |
| frame_rcvd | input | 1 | One-cycle strobe: a frame entered the receive FIFO |
| fifo_rd | input | 1 | One-cycle strobe: software read the receive FIFO |
| bit_tick | input | 1 | One-cycle strobe per serial bit time |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for the address of the previous cycle |
| irq | output | 1 | Registered combined interrupt request |

## Verification
A wrong time-out counter shows up as raw bit 1 rising one or more ticks away from the 32nd quiet tick. It is visible one cycle later on a read of address 1, or on `irq` when bit 1 is enabled. A lost or stuck overrun flag shows up in the first raw read after the full-FIFO frame or after the clear write. Wrong enable or mask state shows on address 0 or 2 and on `irq` exactly one cycle after the cause. The bench therefore compares every output on every cycle against a model.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  typedef enum logic [1:0] {
    ADR_EN  = 2'd0,
    ADR_RAW = 2'd1,
    ADR_MSK = 2'd2,
    ADR_CLR = 2'd3
  } reg_adr_e;

  localparam int B_OVR  = 0;
  localparam int B_TOUT = 1;
  localparam int B_RXH  = 2;
  localparam int B_TXH  = 3;
  localparam int NSRC   = 4;
  localparam int DW     = 8;
endpackage

// File: rtl/spi_irq_tout.sv
module spi_irq_tout #(
  parameter int TOUT_BITS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_empty,
  input  logic frame_rcvd,
  input  logic fifo_rd,
  input  logic bit_tick,
  input  logic clr_req,
  output logic tout
);
  localparam int CW = $clog2(TOUT_BITS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TOUT_BITS);
  localparam logic [CW-1:0] LAST  = CW'(TOUT_BITS - 1);

  logic [CW-1:0] cnt;
  logic          quiet;

  assign quiet = !rx_empty && !frame_rcvd && !fifo_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!quiet) begin
      cnt <= '0;
    end else if (bit_tick && cnt != LIMIT) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tout <= 1'b0;
    end else if (frame_rcvd) begin
      tout <= 1'b0;
    end else if (clr_req && rx_empty) begin
      tout <= 1'b0;
    end else if (quiet && bit_tick && cnt == LAST) begin
      tout <= 1'b1;
    end
  end

  // R3: the quiet-time counter never runs past its limit
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT);
  // R3: any read restarts the count
  a_r3_read_restarts: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |=> cnt == '0);
  // R5: an arriving frame drops the time-out
  a_r5_frame_drops: assert property (@(posedge clk) disable iff (rst)
    frame_rcvd |=> !tout);
endmodule

// File: rtl/spi_irq_ovr.sv
module spi_irq_ovr (
  input  logic clk,
  input  logic rst,
  input  logic rx_full,
  input  logic frame_rcvd,
  input  logic clr_req,
  output logic ovr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ovr <= 1'b0;
    end else if (frame_rcvd && rx_full) begin
      ovr <= 1'b1;
    end else if (clr_req) begin
      ovr <= 1'b0;
    end
  end

  // R4: a frame into a full FIFO always records an overrun
  a_r4_ovr_sets: assert property (@(posedge clk) disable iff (rst)
    frame_rcvd && rx_full |=> ovr);
  // R4: the flag holds until a clear arrives
  a_r4_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    ovr && !clr_req |=> ovr);
endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
  import spi_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  input  logic [NSRC-1:0] raw,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq
);
  logic [NSRC-1:0] en;
  logic [NSRC-1:0] masked;
  logic [DW-1:0]   rd_mux;
  reg_adr_e        adr;

  assign adr = reg_adr_e'(reg_addr);

  for (genvar i = 0; i < NSRC; i++) begin : g_mask
    assign masked[i] = raw[i] & en[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= '0;
    end else if (reg_wr && adr == ADR_EN) begin
      en <= reg_wdata[NSRC-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (adr)
      ADR_EN:  rd_mux[NSRC-1:0] = en;
      ADR_RAW: rd_mux[NSRC-1:0] = raw;
      ADR_MSK: rd_mux[NSRC-1:0] = masked;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      reg_rdata <= rd_mux;
      irq       <= |masked;
    end
  end

  // R8: no request without a source that was enabled a cycle earlier
  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(en) != '0);
  // R9: upper read bits stay clear
  a_r9_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DW-1:NSRC] == '0);
  // R2: enables move only on a write to their own address
  a_r2_en_stable: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && adr == ADR_EN) |=> $stable(en));
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
  import spi_irq_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int TOUT_BITS = 32,
  parameter int LVL_W     = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             frame_rcvd,
  input  logic             fifo_rd,
  input  logic             bit_tick,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             irq
);
  localparam logic [LVL_W-1:0] HALF = LVL_W'(DEPTH / 2);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  logic            rx_empty, rx_full;
  logic            clr_wr;
  logic [NSRC-1:0] raw;

  assign rx_empty = (rx_level == '0);
  assign rx_full  = (rx_level == FULL);
  assign clr_wr   = reg_wr && (reg_addr == ADR_CLR);

  assign raw[B_RXH] = (rx_level >= HALF);
  assign raw[B_TXH] = (tx_level <= FULL - HALF);

  spi_irq_ovr u_ovr (
    .clk        (clk),
    .rst        (rst),
    .rx_full    (rx_full),
    .frame_rcvd (frame_rcvd),
    .clr_req    (clr_wr && reg_wdata[B_OVR]),
    .ovr        (raw[B_OVR])
  );

  spi_irq_tout #(.TOUT_BITS(TOUT_BITS)) u_tout (
    .clk        (clk),
    .rst        (rst),
    .rx_empty   (rx_empty),
    .frame_rcvd (frame_rcvd),
    .fifo_rd    (fifo_rd),
    .bit_tick   (bit_tick),
    .clr_req    (clr_wr && reg_wdata[B_TOUT]),
    .tout       (raw[B_TOUT])
  );

  spi_irq_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .raw       (raw),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  // R5: a pending time-out survives a clear write while data waits
  a_r5_clr_needs_empty: assert property (@(posedge clk) disable iff (rst)
    raw[B_TOUT] && !rx_empty && !frame_rcvd |=> raw[B_TOUT]);
endmodule

// File: tb/spi_irq_unit_bench.sv
module spi_irq_unit_bench;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 8;
  localparam int TB     = 32;
  localparam int LW     = $clog2(DEPTH + 1);

  logic          clk = 0;
  logic          rst = 1;
  logic [LW-1:0] rx_level = 0, tx_level = 0;
  logic          frame_rcvd = 0, fifo_rd = 0, bit_tick = 0, reg_wr = 0;
  logic [1:0]    reg_addr = 0;
  logic [7:0]    reg_wdata = 0;
  logic [7:0]    reg_rdata;
  logic          irq;

  int errors = 0, checks = 0;
  logic [3:0] m_en = 0;
  logic       m_ovr = 0, m_tout = 0;
  int         m_cnt = 0;

  always #(CLK_NS/2) clk = ~clk;

  spi_irq_unit #(.DEPTH(DEPTH), .TOUT_BITS(TB)) u_spi_irq_unit (
    .clk(clk), .rst(rst), .rx_level(rx_level), .tx_level(tx_level),
    .frame_rcvd(frame_rcvd), .fifo_rd(fifo_rd), .bit_tick(bit_tick),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  function automatic logic [3:0] f_raw(int rxl, int txl, logic ovr, logic tout);
    return {txl <= DEPTH - DEPTH/2, rxl >= DEPTH/2, tout, ovr};
  endfunction

  function automatic logic [7:0] f_read(int a, logic [3:0] raw, logic [3:0] en);
    case (a)
      0: return {4'b0, en};
      1: return {4'b0, raw};
      2: return {4'b0, raw & en};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(int rxl, int txl, bit fr, bit rd, bit tk,
                      bit wr, int a, logic [7:0] wd, string tag);
    logic [3:0] raw;
    logic [7:0] exp_rd;
    bit exp_irq, empty, clr;
    @(negedge clk);
    rx_level = LW'(rxl); tx_level = LW'(txl);
    frame_rcvd = fr; fifo_rd = rd; bit_tick = tk;
    reg_wr = wr; reg_addr = 2'(a); reg_wdata = wd;
    raw     = f_raw(rxl, txl, m_ovr, m_tout);
    exp_rd  = f_read(a, raw, m_en);
    exp_irq = |(raw & m_en);
    empty   = (rxl == 0);
    clr     = wr && a == 3;
    @(posedge clk); #1;
    chk(tag, reg_rdata, exp_rd);
    chk("R8", {7'b0, irq}, {7'b0, exp_irq});
    if (fr && rxl == DEPTH) m_ovr = 1;
    else if (clr && wd[0]) m_ovr = 0;
    if (fr) m_tout = 0;
    else if (clr && wd[1] && empty) m_tout = 0;
    else if (!empty && !rd && tk && m_cnt == TB - 1) m_tout = 1;
    if (fr || rd || empty) m_cnt = 0;
    else if (tk && m_cnt != TB) m_cnt++;
    if (wr && a == 0) m_en = wd[3:0];
  endtask

  function automatic string tag_of(int a);
    case (a)
      0: return "R2";
      1: return "R7";
      2: return "R7";
      default: return "R9";
    endcase
  endfunction

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(1234);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    chk("R1", {7'b0, irq}, 8'h00);
    step(0, 0, 0, 0, 0, 0, 1, 0, "R1");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R1");
    // R9: reserved enable bits and status addresses ignore writes
    step(0, 0, 0, 0, 0, 1, 0, 8'hF0, "R9");
    step(0, 0, 0, 0, 0, 1, 1, 8'hFF, "R9");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 1, 0, "R9");
    // R6: level thresholds
    step(3, 5, 0, 0, 0, 0, 1, 0, "R6");
    step(4, 4, 0, 0, 0, 0, 1, 0, "R6");
    step(4, 5, 0, 0, 0, 0, 1, 0, "R6");
    // R3: 31 quiet ticks leave bit 1 low, the 32nd sets it
    step(1, 8, 0, 1, 0, 1, 0, 8'h02, "R3");
    for (int i = 0; i < TB - 1; i++) step(1, 8, 0, 0, 1, 0, 1, 0, "R3");
    step(1, 8, 0, 0, 0, 0, 1, 0, "R3");
    step(1, 8, 0, 0, 1, 0, 1, 0, "R3");
    step(1, 8, 0, 0, 0, 0, 1, 0, "R3");
    // R5: clear with data pending keeps it, frame drops it
    step(1, 8, 0, 0, 0, 1, 3, 8'h02, "R5");
    step(1, 8, 0, 0, 0, 0, 1, 0, "R5");
    step(1, 8, 1, 0, 0, 0, 1, 0, "R5");
    step(2, 8, 0, 0, 0, 0, 1, 0, "R5");
    // R4: overrun set, sticky, cleared
    step(8, 8, 1, 0, 0, 1, 0, 8'h01, "R4");
    step(8, 8, 0, 0, 0, 0, 2, 0, "R4");
    step(3, 8, 0, 1, 0, 0, 1, 0, "R4");
    step(3, 8, 0, 0, 0, 1, 3, 8'h01, "R4");
    step(3, 8, 0, 0, 0, 0, 1, 0, "R4");
    // constrained random run
    for (int n = 0; n < 4000; n++) begin
      int rxl, txl, a;
      bit fr, rd, tk, wr;
      rxl = ($urandom % 4 == 0) ? DEPTH : int'($urandom % 3);
      txl = int'($urandom % (DEPTH + 1));
      fr  = ($urandom % 40) == 0;
      rd  = ($urandom % 50) == 0;
      tk  = ($urandom % 2) == 0;
      wr  = ($urandom % 12) == 0;
      a   = int'($urandom % 4);
      for (int k = 0; k < 20; k++) begin
        step(rxl, txl, fr && k == 0, rd && k == 5, tk, wr && k == 3, a,
             8'($urandom), tag_of(a));
      end
      n += 19;
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule